// File: doc/BRIEF.md
# Tagged Write Beat Checker

This block is a passive monitor for a write bus on which several transactions can be in flight at once. Each transaction is named by a 4-bit tag. When a write request is accepted, the monitor stores that transaction's expected payload, which is a 128-bit vector holding up to sixteen byte-wide beats. After that, every data beat that carries the same tag is compared with the byte selected by that tag's own beat counter. Beats for different tags may be interleaved in any order.

The bus may order a retry for a transaction at any time from acceptance up to and including the cycle after its final beat. A retry rewinds that transaction to its first byte. There is no new request, and a transaction may be retried any number of times. The monitor reports a wrong or unexpected beat with a one-cycle error pulse that carries the tag. It reports a finished transaction with a one-cycle completion pulse that carries the tag, and it then frees that tag's context.

Top module: `wbeat_checker`

## Requirements
- R1: While `rst` is high, every context returns to idle and `err_o` and `done_o` stay low. After reset, a beat to any tag is treated as a beat to an unopened tag.
- R2: A tag is opened when `wr_req_i` and `wr_ack_i` are high in the same cycle. At that edge, `ack_tag_i` selects the context, and `exp_data_i` is stored in it with the beat counter set to zero.
- R3: The first beat of a transaction must equal `exp_data_i[127:120]`, and beat k must equal the byte k positions lower. After each accepted beat that is not the last, the counter advances by one. A mismatch raises `err_o` with `err_tag_o` equal to the beat's tag, one clock edge after the edge that samples the beat.
- R4: A beat counts only for the context whose tag equals `beat_tag_i` while `beat_vld_i` is high. Interleaved tags keep independent counters and independent expected data.
- R5: A beat whose tag has no open transaction raises `err_o` with that tag.
- R6: `beat_last_i`, given together with a beat, marks the final beat. If no matching retry is sampled at the next edge, `done_o` pulses with `done_tag_o` one edge after that edge, and the tag returns to idle. A later beat to that tag is then flagged as in R5.
- R7: A matching retry at any edge after acceptance, including the edge that follows the final beat, rewinds the counter to zero and cancels completion. Retries are unlimited.
- R8: If a matching beat and a matching retry are sampled at the same edge, the beat is still compared against the current counter, and the counter then goes to zero.
- R9: Once sixteen beats have been accepted without a final-beat mark, any further beat for that tag raises `err_o`.
- R10: A retry for an idle tag has no effect. The tag stays unopened.
- R11: All sixteen tags can be open at the same time, and each completes on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_req_i | input | 1 | Write request |
| wr_ack_i | input | 1 | Write request accepted |
| ack_tag_i | input | 4 | Tag given to the accepted request |
| exp_data_i | input | 128 | Expected payload; the first beat is in the top byte |
| beat_vld_i | input | 1 | Data beat present |
| beat_tag_i | input | 4 | Tag of the data beat |
| beat_data_i | input | 8 | Beat byte |
| beat_last_i | input | 1 | Beat is the final one |
| retry_i | input | 1 | Retry order |
| retry_tag_i | input | 4 | Tag being retried |
| err_o | output | 1 | One-cycle error pulse |
| err_tag_o | output | 4 | Tag of the flagged beat |
| done_o | output | 1 | One-cycle completion pulse |
| done_tag_o | output | 4 | Tag of the completed transaction |

## Verification
The bench goes after the retry window. A retry in the cycle after the final beat must suppress completion. A design that closed the window one cycle early would report a completion and then flag the replayed beats as unopened. A beat sampled together with its own retry must be compared against the byte selected before the rewind and must leave the counter at zero. Getting this wrong gives a false error either on that beat or on the replayed first byte. The seventeenth beat, a retry to an idle tag, reuse of a tag after completion, and sixteen tags interleaved at once each have a cycle-exact expectation. A design that let its counter wrap, or let one tag's state leak into another, would produce misplaced or missing pulses.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

    typedef enum logic [1:0] {
        CTX_IDLE = 2'd0,
        CTX_BUSY = 2'd1,
        CTX_TAIL = 2'd2
    } ctx_state_e;

endpackage

// File: rtl/wbc_ctx.sv
module wbc_ctx
    import wbc_pkg::*;
#(
    parameter int BEAT_W    = 8,
    parameter int MAX_BEATS = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        open_i,
    input  logic [BEAT_W*MAX_BEATS-1:0] exp_i,
    input  logic                        beat_i,
    input  logic [BEAT_W-1:0]           data_i,
    input  logic                        last_i,
    input  logic                        retry_i,
    output logic                        beat_err_o,
    output logic                        done_o
);
    localparam int EXP_W = BEAT_W * MAX_BEATS;
    localparam int CNT_W = $clog2(MAX_BEATS + 1);

    typedef struct packed {
        ctx_state_e       st;
        logic [CNT_W-1:0] idx;
        logic [EXP_W-1:0] exp;
    } ctx_t;

    ctx_t              ctx_d, ctx_q;
    logic [BEAT_W-1:0] exp_byte;
    logic              at_limit;

    always_comb begin
        exp_byte = '0;
        for (int k = 0; k < MAX_BEATS; k++) begin
            if (ctx_q.idx == CNT_W'(k)) exp_byte = ctx_q.exp[EXP_W-1-k*BEAT_W -: BEAT_W];
        end
    end

    assign at_limit = (ctx_q.idx == CNT_W'(MAX_BEATS));

    always_comb begin
        ctx_d      = ctx_q;
        beat_err_o = 1'b0;
        done_o     = 1'b0;
        unique case (ctx_q.st)
            CTX_IDLE: begin
                if (beat_i) beat_err_o = 1'b1;
            end
            CTX_BUSY: begin
                if (beat_i) begin
                    if (at_limit || (data_i != exp_byte)) beat_err_o = 1'b1;
                    if (retry_i)          ctx_d.idx = '0;
                    else if (last_i)      ctx_d.st  = CTX_TAIL;
                    else if (!at_limit)   ctx_d.idx = ctx_q.idx + 1'b1;
                end else if (retry_i) begin
                    ctx_d.idx = '0;
                end
            end
            CTX_TAIL: begin
                if (beat_i) beat_err_o = 1'b1;
                if (retry_i) begin
                    ctx_d.st  = CTX_BUSY;
                    ctx_d.idx = '0;
                end else begin
                    done_o   = 1'b1;
                    ctx_d.st = CTX_IDLE;
                end
            end
            default: ctx_d.st = CTX_IDLE;
        endcase
        if (open_i) begin
            ctx_d.st  = CTX_BUSY;
            ctx_d.idx = '0;
            ctx_d.exp = exp_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q.st  <= CTX_IDLE;
            ctx_q.idx <= '0;
            ctx_q.exp <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    AST_OPEN_LOADS: assert property (@(posedge clk) disable iff (rst)
        open_i |=> (ctx_q.st == CTX_BUSY) && (ctx_q.idx == '0) && (ctx_q.exp == $past(exp_i))); // R2

    AST_BEAT_STEPS: assert property (@(posedge clk) disable iff (rst)
        (ctx_q.st == CTX_BUSY && beat_i && !last_i && !retry_i && !open_i && !at_limit)
        |=> ctx_q.idx == $past(ctx_q.idx) + 1'b1); // R3

    AST_RETRY_REWINDS: assert property (@(posedge clk) disable iff (rst)
        (ctx_q.st != CTX_IDLE && retry_i) |=> ctx_q.idx == '0); // R7

    AST_TAIL_BRIEF: assert property (@(posedge clk) disable iff (rst)
        (ctx_q.st == CTX_TAIL) |=> ctx_q.st != CTX_TAIL); // R6

endmodule

// File: rtl/wbc_report.sv
module wbc_report #(
    parameter int NUM_TAGS = 16,
    parameter int TAG_W    = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_TAGS-1:0] berr_vec_i,
    input  logic [NUM_TAGS-1:0] done_vec_i,
    output logic                err_o,
    output logic [TAG_W-1:0]    err_tag_o,
    output logic                done_o,
    output logic [TAG_W-1:0]    done_tag_o
);
    typedef struct packed {
        logic             err;
        logic [TAG_W-1:0] err_tag;
        logic             done;
        logic [TAG_W-1:0] done_tag;
    } rep_t;

    rep_t rep_d, rep_q;

    always_comb begin
        rep_d      = '0;
        rep_d.err  = |berr_vec_i;
        rep_d.done = |done_vec_i;
        for (int t = NUM_TAGS - 1; t >= 0; t--) begin
            if (berr_vec_i[t]) rep_d.err_tag  = TAG_W'(t);
            if (done_vec_i[t]) rep_d.done_tag = TAG_W'(t);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rep_q <= '0;
        else     rep_q <= rep_d;
    end

    assign err_o      = rep_q.err;
    assign err_tag_o  = rep_q.err_tag;
    assign done_o     = rep_q.done;
    assign done_tag_o = rep_q.done_tag;

    AST_ONE_BEAT_OWNER: assert property (@(posedge clk) disable iff (rst)
        $onehot0(berr_vec_i)); // R4

    AST_ONE_COMPLETION: assert property (@(posedge clk) disable iff (rst)
        $onehot0(done_vec_i)); // R6

endmodule

// File: rtl/wbeat_checker.sv
module wbeat_checker #(
    parameter int TAG_W     = 4,
    parameter int BEAT_W    = 8,
    parameter int MAX_BEATS = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_req_i,
    input  logic                        wr_ack_i,
    input  logic [TAG_W-1:0]            ack_tag_i,
    input  logic [BEAT_W*MAX_BEATS-1:0] exp_data_i,
    input  logic                        beat_vld_i,
    input  logic [TAG_W-1:0]            beat_tag_i,
    input  logic [BEAT_W-1:0]           beat_data_i,
    input  logic                        beat_last_i,
    input  logic                        retry_i,
    input  logic [TAG_W-1:0]            retry_tag_i,
    output logic                        err_o,
    output logic [TAG_W-1:0]            err_tag_o,
    output logic                        done_o,
    output logic [TAG_W-1:0]            done_tag_o
);
    localparam int NUM_TAGS = 1 << TAG_W;

    logic [NUM_TAGS-1:0] berr_vec;
    logic [NUM_TAGS-1:0] done_vec;
    logic                accept;

    assign accept = wr_req_i && wr_ack_i;

    for (genvar t = 0; t < NUM_TAGS; t++) begin : g_ctx
        logic open_t, beat_t, retry_t;
        assign open_t  = accept     && (ack_tag_i   == TAG_W'(t));
        assign beat_t  = beat_vld_i && (beat_tag_i  == TAG_W'(t));
        assign retry_t = retry_i    && (retry_tag_i == TAG_W'(t));

        wbc_ctx #(
            .BEAT_W    (BEAT_W),
            .MAX_BEATS (MAX_BEATS)
        ) u_ctx (
            .clk        (clk),
            .rst        (rst),
            .open_i     (open_t),
            .exp_i      (exp_data_i),
            .beat_i     (beat_t),
            .data_i     (beat_data_i),
            .last_i     (beat_last_i),
            .retry_i    (retry_t),
            .beat_err_o (berr_vec[t]),
            .done_o     (done_vec[t])
        );
    end

    wbc_report #(
        .NUM_TAGS (NUM_TAGS),
        .TAG_W    (TAG_W)
    ) u_report (
        .clk        (clk),
        .rst        (rst),
        .berr_vec_i (berr_vec),
        .done_vec_i (done_vec),
        .err_o      (err_o),
        .err_tag_o  (err_tag_o),
        .done_o     (done_o),
        .done_tag_o (done_tag_o)
    );

endmodule

// File: tb/wbeat_checker_test.sv
module wbeat_checker_test;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_req, wr_ack, beat_vld, beat_last, retry;
    logic [3:0]   ack_tag, beat_tag, retry_tag;
    logic [127:0] exp_data;
    logic [7:0]   beat_data;
    logic         err_o, done_o;
    logic [3:0]   err_tag_o, done_tag_o;

    always #10 clk = ~clk;

    wbeat_checker uut (
        .clk(clk), .rst(rst),
        .wr_req_i(wr_req), .wr_ack_i(wr_ack), .ack_tag_i(ack_tag), .exp_data_i(exp_data),
        .beat_vld_i(beat_vld), .beat_tag_i(beat_tag), .beat_data_i(beat_data),
        .beat_last_i(beat_last), .retry_i(retry), .retry_tag_i(retry_tag),
        .err_o(err_o), .err_tag_o(err_tag_o), .done_o(done_o), .done_tag_o(done_tag_o)
    );

    typedef struct {
        bit     is_done;
        int     tag;
        int     cyc;
        string  req;
    } item_t;

    item_t sb[$];
    int    cyc = 0;
    int    last_drv = 0;
    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] byte_of(int seed, int k);
        return 8'(seed * 37 + k * 11 + 5);
    endfunction

    function automatic logic [127:0] mk_exp(int seed);
        logic [127:0] v;
        for (int k = 0; k < 16; k++) v[127-8*k -: 8] = byte_of(seed, k);
        return v;
    endfunction

    task automatic push(bit is_done, int tag, int at, string r);
        item_t it;
        it.is_done = is_done; it.tag = tag; it.cyc = at; it.req = r;
        sb.push_back(it);
    endtask

    task automatic clear_inputs();
        wr_req = 0; wr_ack = 0; ack_tag = 0; exp_data = '0;
        beat_vld = 0; beat_tag = 0; beat_data = 0; beat_last = 0;
        retry = 0; retry_tag = 0;
    endtask

    task automatic idle();
        @(negedge clk); clear_inputs();
    endtask

    task automatic open_tag(int tag, int seed);
        @(negedge clk); clear_inputs();
        wr_req = 1; wr_ack = 1; ack_tag = 4'(tag); exp_data = mk_exp(seed);
    endtask

    task automatic beat(int tag, logic [7:0] d, bit last, bit with_retry, bit bad, string r);
        @(negedge clk); clear_inputs();
        beat_vld = 1; beat_tag = 4'(tag); beat_data = d; beat_last = last;
        if (with_retry) begin retry = 1; retry_tag = 4'(tag); end
        last_drv = cyc;
        if (bad) push(1'b0, tag, cyc + 1, r);
    endtask

    task automatic do_retry(int tag);
        @(negedge clk); clear_inputs();
        retry = 1; retry_tag = 4'(tag);
    endtask

    task automatic expect_done(int tag, string r);
        push(1'b1, tag, last_drv + 2, r);
    endtask

    // Scoreboard monitor: matches each output pulse against the queued items
    task automatic match_kind(bit is_done, logic pulse, logic [3:0] tag);
        int found = -1;
        for (int i = 0; i < sb.size(); i++)
            if (found < 0 && sb[i].is_done == is_done && sb[i].cyc == cyc) found = i;
        if (pulse) begin
            checks++;
            if (found < 0) begin
                errors++;
                $display("FAIL %s: unexpected %s pulse tag=%0d at cycle %0d (expected none)",
                         cur_req, is_done ? "done" : "err", tag, cyc);
            end else begin
                if (int'(tag) != sb[found].tag) begin
                    errors++;
                    $display("FAIL %s: %s tag actual=%0d expected=%0d", sb[found].req,
                             is_done ? "done" : "err", tag, sb[found].tag);
                end
                sb.delete(found);
            end
        end else if (found >= 0) begin
            checks++; errors++;
            $display("FAIL %s: missing %s pulse actual=0 expected=1 tag=%0d cycle %0d",
                     sb[found].req, is_done ? "done" : "err", sb[found].tag, cyc);
            sb.delete(found);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            match_kind(1'b0, err_o, err_tag_o);
            match_kind(1'b1, done_o, done_tag_o);
        end
    end

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not end actual=hung expected=done");
            report();
        end
    end

    initial begin
        clear_inputs();
        repeat (3) @(negedge clk);
        // R1: outputs low during reset
        checks++;
        if (err_o !== 1'b0 || done_o !== 1'b0) begin
            errors++;
            $display("FAIL R1: reset outputs actual=%b%b expected=00", err_o, done_o);
        end
        rst = 0;
        idle();

        // R1 / R5: beat to a tag never opened
        cur_req = "R5";
        beat(3, 8'h00, 0, 0, 1, "R5");
        idle();

        // R2 / R3 / R6: clean four-beat transfer on tag 2
        cur_req = "R3";
        open_tag(2, 1);
        for (int k = 0; k < 4; k++) beat(2, byte_of(1, k), k == 3, 0, 0, "R3");
        expect_done(2, "R6");
        idle(); idle();
        cur_req = "R6";
        beat(2, byte_of(1, 0), 0, 0, 1, "R6");  // context freed
        idle();

        // R3: mismatch on second beat
        cur_req = "R3";
        open_tag(5, 2);
        beat(5, byte_of(2, 0), 0, 0, 0, "R3");
        beat(5, ~byte_of(2, 1), 0, 0, 1, "R3");
        beat(5, byte_of(2, 2), 1, 0, 0, "R3");
        expect_done(5, "R6");
        idle(); idle();

        // R4: interleaved tags 1 and 9, cross-tag byte flagged
        cur_req = "R4";
        open_tag(1, 3);
        open_tag(9, 4);
        beat(1, byte_of(3, 0), 0, 0, 0, "R4");
        beat(9, byte_of(4, 0), 0, 0, 0, "R4");
        beat(9, byte_of(3, 1), 0, 0, byte_of(3, 1) != byte_of(4, 1), "R4");
        beat(1, byte_of(3, 1), 1, 0, 0, "R4");
        expect_done(1, "R4");
        idle();
        beat(9, byte_of(4, 2), 1, 0, 0, "R4");
        expect_done(9, "R4");
        idle(); idle();

        // R7: retry mid-transfer, retry after last beat, replay twice
        cur_req = "R7";
        open_tag(6, 5);
        beat(6, byte_of(5, 0), 0, 0, 0, "R7");
        beat(6, byte_of(5, 1), 0, 0, 0, "R7");
        do_retry(6);
        beat(6, byte_of(5, 0), 0, 0, 0, "R7");
        beat(6, byte_of(5, 1), 1, 0, 0, "R7");
        do_retry(6);                              // window edge: no completion
        beat(6, byte_of(5, 0), 0, 0, 0, "R7");
        beat(6, byte_of(5, 1), 1, 0, 0, "R7");
        expect_done(6, "R7");
        idle(); idle();

        // R8: beat and retry together
        cur_req = "R8";
        open_tag(7, 6);
        beat(7, byte_of(6, 0), 0, 0, 0, "R8");
        beat(7, byte_of(6, 1), 0, 1, 0, "R8");
        beat(7, byte_of(6, 0), 0, 0, 0, "R8");
        beat(7, byte_of(6, 1), 0, 1, 1'(byte_of(6, 1) != byte_of(6, 1)), "R8");
        beat(7, ~byte_of(6, 0), 0, 1, 1, "R8");
        beat(7, byte_of(6, 0), 1, 0, 0, "R8");
        expect_done(7, "R8");
        idle(); idle();

        // R9: seventeenth beat
        cur_req = "R9";
        open_tag(8, 7);
        for (int k = 0; k < 16; k++) beat(8, byte_of(7, k), 0, 0, 0, "R9");
        beat(8, byte_of(7, 0), 0, 0, 1, "R9");
        do_retry(8);
        beat(8, byte_of(7, 0), 1, 0, 0, "R9");
        expect_done(8, "R9");
        idle(); idle();

        // R10: retry on an idle tag is ignored
        cur_req = "R10";
        do_retry(11);
        idle();
        beat(11, 8'h00, 0, 0, 1, "R10");
        idle(); idle();

        // R11: all sixteen tags open concurrently
        cur_req = "R11";
        for (int t = 0; t < 16; t++) open_tag(t, 100 + t);
        for (int k = 0; k < 3; k++)
            for (int t = 0; t < 16; t++) begin
                beat(t, byte_of(100 + t, k), k == 2, 0, 0, "R11");
                if (k == 2) expect_done(t, "R11");
            end
        repeat (4) idle();

        while (sb.size() > 0) begin
            checks++; errors++;
            $display("FAIL %s: pending %s pulse actual=none expected=tag %0d",
                     sb[0].req, sb[0].is_done ? "done" : "err", sb[0].tag);
            void'(sb.pop_front());
        end
        finished = 1'b1;
        report();
    end

endmodule